// File: doc/BRIEF.md
# Multi-Byte UART FIFO Word Bridge

This block connects a 32-bit memory-mapped register bus to the byte-wide receive and transmit FIFOs of a four-channel UART. One bus read can drain several received bytes at once and return them packed into a single word. One bus write can load up to four bytes into a transmit FIFO. The bridge works out the channel and the access window from the address. It then runs the pops or pushes one byte per clock, places each byte in its lane, and returns a single response per request.

Each channel has two windows. The plain window carries bytes only, and serves both reads (receive) and writes (transmit). The paired window is read-only. It returns each received byte next to the line-status value that came with it, so a word read yields two status/data pairs and a half-word read yields one. Reads that ask for more bytes than the FIFO holds stop at the last available byte and zero-fill the lanes that were not loaded. Writes stop when the transmit FIFO fills. The bytes that do not fit are dropped, and a sticky per-channel overflow flag is raised.

The FIFOs are expected to be show-ahead. The head byte and its status are visible whenever the empty flag is low, and a pop or push takes effect at the clock edge.

Top module: `uart_word_bridge`

## Requirements
- R1: The request page field `req_page` decodes as follows. Bits [3:2] select the channel. Bits [1:0] select the window: 2'b01 is the plain window and 2'b10 is the paired window. Window codes 2'b00 and 2'b11 give `rsp_err`=1 and `rsp_rdata`=0, and cause no pop and no push.
- R2: A plain-window read with `req_size` 0, 1 or 2 (byte, half-word, word) pops up to 1, 2 or 4 bytes. The oldest byte goes to bits [7:0], and each later byte goes to the next higher lane. A `req_size` of 3 is an error.
- R3: A word read of the paired window pops up to two bytes. The word is laid out as status n+0 in [7:0], data n+0 in [15:8], status n+1 in [23:16] and data n+1 in [31:24].
- R4: A half-word read of the paired window pops exactly one byte. The status goes in [7:0], the data in [15:8], and [31:16] read as zero.
- R5: A byte read (`req_size`=0) of the paired window gives `rsp_err`=1 and `rsp_rdata`=0, and pops nothing.
- R6: A read stops at the first empty cycle. Lanes that were not filled read as zero, `rsp_err` stays 0, and a pop is never issued to an empty FIFO.
- R7: A write to the plain window pushes, on `tx_data`, each lane whose `req_be` bit is set, in ascending lane order. A write to the paired window is an error and pushes nothing. A write with `req_be`=0 completes with no push.
- R8: When an enabled lane meets a full transmit FIFO, that lane and every later lane are dropped. `tx_ovf` for that channel is set, and it stays set until reset.
- R9: Back-to-back accesses continue the FIFO byte sequence with no loss or repetition.
- R10: After reset, `req_ready`=1, `rsp_valid`=0, `tx_ovf`=0, and no pop or push is issued. `req_ready` is low while a request is in progress. Every accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R11: Only the FIFO of the addressed channel is popped or pushed, and at most one pop or push happens per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request accepted when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 4 | Address bits [11:8]: channel [3:2], window [1:0] |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 invalid |
| req_be | input | 4 | Write byte enables, one per lane |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Read data |
| rx_empty | input | 4 | Receive FIFO empty, per channel |
| rx_data | input | 32 | Receive head byte, channel c in [8c+7:8c] |
| rx_stat | input | 32 | Receive head line status, channel c in [8c+7:8c] |
| rx_pop | output | 4 | Receive pop strobe, per channel |
| tx_full | input | 4 | Transmit FIFO full, per channel |
| tx_push | output | 4 | Transmit push strobe, per channel |
| tx_data | output | 8 | Byte being pushed |
| tx_ovf | output | 4 | Sticky transmit overflow, per channel |

## Verification
Assertions check several properties on every cycle:
- no pop is issued to an empty FIFO and no push to a full one;
- strobes are one-hot and never mix pop with push;
- the overflow flags are sticky;
- byte reads of the paired window and invalid windows are answered with an error in the very next cycle.

Only the bench scenarios can show the rest: the lane order of packed words, how status bytes interleave with data, zero-fill on short reads, the order of bytes pushed under sparse byte enables, and the continuation of the byte stream across successive accesses. These are checked against a queue-based model of the FIFOs.

// File: rtl/uwb_pkg.sv
package uwb_pkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = BUS_BYTES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    WIN_NONE   = 2'b00,
    WIN_PLAIN  = 2'b01,
    WIN_PAIRED = 2'b10,
    WIN_RSVD   = 2'b11
  } win_e;

  typedef struct packed {
    logic       write;
    logic       paired;
    logic       err;
    logic [2:0] nsteps;
  } cmd_t;
endpackage

// File: rtl/uwb_decode.sv
module uwb_decode
  import uwb_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic [CH_W+1:0] page,
  input  logic            write,
  input  logic [1:0]      size,
  input  logic [3:0]      be,
  output logic [CH_W-1:0] ch,
  output cmd_t            cmd
);
  win_e win;
  logic ch_bad;

  assign win    = win_e'(page[1:0]);
  assign ch     = page[2 +: CH_W];
  assign ch_bad = (int'(ch) >= NCH);

  always_comb begin
    cmd        = '0;
    cmd.write  = write;
    cmd.paired = (win == WIN_PAIRED);
    if (ch_bad || win == WIN_NONE || win == WIN_RSVD) begin
      cmd.err = 1'b1;
    end else if (write) begin
      if (win == WIN_PAIRED) cmd.err = 1'b1;
      else                   cmd.nsteps = (be == 4'd0) ? 3'd0 : 3'd4;
    end else if (win == WIN_PLAIN) begin
      case (size_e'(size))
        SZ_BYTE: cmd.nsteps = 3'd1;
        SZ_HALF: cmd.nsteps = 3'd2;
        SZ_WORD: cmd.nsteps = 3'd4;
        default: cmd.err    = 1'b1;
      endcase
    end else begin
      case (size_e'(size))
        SZ_HALF: cmd.nsteps = 3'd1;
        SZ_WORD: cmd.nsteps = 3'd2;
        default: cmd.err    = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/uwb_lane_pack.sv
module uwb_lane_pack
  import uwb_pkg::*;
(
  input  logic [BUS_W-1:0] acc,
  input  logic [1:0]       step,
  input  logic             paired,
  input  logic             en,
  input  logic [7:0]       data,
  input  logic [7:0]       stat,
  output logic [BUS_W-1:0] acc_next
);
  always_comb begin
    acc_next = acc;
    if (en) begin
      if (paired) acc_next[{step[0], 4'b0000} +: 16] = {data, stat};
      else        acc_next[{step, 3'b000} +: 8]      = data;
    end
  end
endmodule

// File: rtl/uwb_seq.sv
module uwb_seq
  import uwb_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  cmd_t             cmd,
  input  logic [CH_W-1:0]  ch_in,
  input  logic [3:0]       be,
  input  logic [BUS_W-1:0] wdata,
  input  logic             cur_empty,
  input  logic             cur_full,
  input  logic [7:0]       cur_data,
  input  logic [7:0]       cur_stat,
  output logic [CH_W-1:0]  ch_q,
  output logic             pop,
  output logic             push,
  output logic [7:0]       push_data,
  output logic             ovf_set,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [BUS_W-1:0] rsp_rdata
);
  typedef enum logic {S_IDLE, S_RUN} st_e;

  st_e              st_q;
  logic             wr_q, pr_q;
  logic [2:0]       step_q, last_q;
  logic [3:0]       be_q;
  logic [BUS_W-1:0] wd_q, acc_q, acc_next;
  logic             run, accept, lane_en, at_last, finish;

  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign run       = (st_q == S_RUN);
  assign lane_en   = be_q[step_q[1:0]];
  assign at_last   = (step_q == last_q);
  assign pop       = run && !wr_q && !cur_empty;
  assign push      = run && wr_q && lane_en && !cur_full;
  assign ovf_set   = run && wr_q && lane_en && cur_full;
  assign push_data = wd_q[{step_q[1:0], 3'b000} +: 8];
  assign finish    = run && (wr_q ? (ovf_set || at_last) : (cur_empty || at_last));

  uwb_lane_pack u_pack (
    .acc      (acc_q),
    .step     (step_q[1:0]),
    .paired   (pr_q),
    .en       (pop),
    .data     (cur_data),
    .stat     (cur_stat),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      ch_q      <= '0;
      wr_q      <= 1'b0;
      pr_q      <= 1'b0;
      step_q    <= '0;
      last_q    <= '0;
      be_q      <= '0;
      wd_q      <= '0;
      acc_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        ch_q   <= ch_in;
        wr_q   <= cmd.write;
        pr_q   <= cmd.paired;
        be_q   <= be;
        wd_q   <= wdata;
        step_q <= '0;
        last_q <= cmd.nsteps - 3'd1;
        acc_q  <= '0;
        if (cmd.err || cmd.nsteps == 3'd0) begin
          rsp_valid <= 1'b1;
          rsp_err   <= cmd.err;
          rsp_rdata <= '0;
        end else begin
          st_q <= S_RUN;
        end
      end
      if (run) begin
        acc_q  <= acc_next;
        step_q <= step_q + 3'd1;
        if (finish) begin
          st_q      <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= acc_next;
        end
      end
    end
  end

  // R10: a response is only given once the sequencer is idle again
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
  // R11: a cycle never both pops and pushes
  assert_no_mix_R11: assert property (@(posedge clk) disable iff (rst)
    !(pop && push));
endmodule

// File: rtl/uart_word_bridge.sv
module uart_word_bridge
  import uwb_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CH_W+1:0]   req_page,
  input  logic [1:0]        req_size,
  input  logic [3:0]        req_be,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic [NCH-1:0]    rx_empty,
  input  logic [NCH*8-1:0]  rx_data,
  input  logic [NCH*8-1:0]  rx_stat,
  output logic [NCH-1:0]    rx_pop,
  input  logic [NCH-1:0]    tx_full,
  output logic [NCH-1:0]    tx_push,
  output logic [7:0]        tx_data,
  output logic [NCH-1:0]    tx_ovf
);
  cmd_t            cmd;
  logic [CH_W-1:0] ch_dec, ch_q;
  logic            pop, push, ovf_set;
  logic            cur_empty, cur_full;
  logic [7:0]      cur_data, cur_stat;

  uwb_decode #(.NCH(NCH), .CH_W(CH_W)) u_dec (
    .page  (req_page),
    .write (req_write),
    .size  (req_size),
    .be    (req_be),
    .ch    (ch_dec),
    .cmd   (cmd)
  );

  assign cur_empty = rx_empty[ch_q];
  assign cur_full  = tx_full[ch_q];
  assign cur_data  = rx_data[ch_q*8 +: 8];
  assign cur_stat  = rx_stat[ch_q*8 +: 8];

  uwb_seq #(.CH_W(CH_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd       (cmd),
    .ch_in     (ch_dec),
    .be        (req_be),
    .wdata     (req_wdata),
    .cur_empty (cur_empty),
    .cur_full  (cur_full),
    .cur_data  (cur_data),
    .cur_stat  (cur_stat),
    .ch_q      (ch_q),
    .pop       (pop),
    .push      (push),
    .push_data (tx_data),
    .ovf_set   (ovf_set),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel, ovf_q;
    assign sel        = (ch_q == CH_W'(i));
    assign rx_pop[i]  = pop && sel;
    assign tx_push[i] = push && sel;
    assign tx_ovf[i]  = ovf_q;

    always_ff @(posedge clk) begin
      if (rst)                ovf_q <= 1'b0;
      else if (ovf_set && sel) ovf_q <= 1'b1;
    end

    // R6: never pop an empty receive FIFO
    assert_pop_not_empty_R6: assert property (@(posedge clk) disable iff (rst)
      rx_pop[i] |-> !rx_empty[i]);
    // R8: never push a full transmit FIFO
    assert_push_not_full_R8: assert property (@(posedge clk) disable iff (rst)
      tx_push[i] |-> !tx_full[i]);
    // R8: overflow flag is sticky
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      tx_ovf[i] |=> tx_ovf[i]);
  end

  // R11: at most one channel strobed per cycle
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_pop, tx_push}));
  // R5: byte read of the paired window is rejected at once
  assert_byte_paired_err_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write && req_page[1:0] == 2'b10 && req_size == 2'd0)
    |=> (rsp_valid && rsp_err && rsp_rdata == '0));
  // R1: unused window codes are rejected at once
  assert_bad_window_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_page[1:0] == 2'b00 || req_page[1:0] == 2'b11))
    |=> (rsp_valid && rsp_err));
endmodule

// File: tb/uart_word_bridge_tb_top.sv
`timescale 1ns/1ps
module uart_word_bridge_tb_top;
  localparam int NCH   = 4;
  localparam int TXCAP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_page = '0, req_be = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  rx_empty = '1, tx_full = '0;
  logic [31:0] rx_data = '0, rx_stat = '0;
  logic [3:0]  rx_pop, tx_push, tx_ovf;
  logic [7:0]  tx_data;

  int checks = 0, failures = 0;
  int exp_ch = 0, pops_seen = 0, txcnt [NCH];
  logic [15:0] rxq [NCH][$];   // {stat, data}
  logic [11:0] exp_tx [$];     // {ch, data}

  always #4 clk = ~clk;

  uart_word_bridge dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_page(req_page), .req_size(req_size),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .rx_empty(rx_empty),
    .rx_data(rx_data), .rx_stat(rx_stat), .rx_pop(rx_pop), .tx_full(tx_full),
    .tx_push(tx_push), .tx_data(tx_data), .tx_ovf(tx_ovf)
  );

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic refresh();
    for (int c = 0; c < NCH; c++) begin
      rx_empty[c]        = (rxq[c].size() == 0);
      rx_data[c*8 +: 8]  = (rxq[c].size() != 0) ? rxq[c][0][7:0] : 8'h00;
      rx_stat[c*8 +: 8]  = (rxq[c].size() != 0) ? rxq[c][0][15:8] : 8'h00;
      tx_full[c]         = (txcnt[c] >= TXCAP);
    end
  endtask

  task automatic load(input int ch, input logic [7:0] d, input logic [7:0] s);
    @(negedge clk);
    rxq[ch].push_back({s, d});
    refresh();
  endtask

  task automatic drain(input int ch);
    @(negedge clk);
    txcnt[ch] = 0;
    refresh();
  endtask

  // FIFO environment and per-cycle comparison of strobes
  always @(posedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++) begin
        if (rx_pop[c]) begin
          check("R11", "pop channel", c, exp_ch);
          if (rxq[c].size() != 0) void'(rxq[c].pop_front());
          pops_seen++;
        end
        if (tx_push[c]) begin
          if (exp_tx.size() == 0) check("R7", "unexpected push", {20'd0, 4'(c), tx_data}, 32'hFFFF_FFFF);
          else begin
            check("R7", "push ch/data", {20'd0, 4'(c), tx_data}, {20'd0, exp_tx[0]});
            void'(exp_tx.pop_front());
          end
          txcnt[c]++;
        end
      end
    end
    for (int c = 0; c < NCH; c++) begin
      rx_empty[c]       <= (rxq[c].size() == 0);
      rx_data[c*8 +: 8] <= (rxq[c].size() != 0) ? rxq[c][0][7:0] : 8'h00;
      rx_stat[c*8 +: 8] <= (rxq[c].size() != 0) ? rxq[c][0][15:8] : 8'h00;
      tx_full[c]        <= (txcnt[c] >= TXCAP);
    end
  end

  task automatic access(input string rq, input bit wr, input int ch, input int win,
                        input int sz, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] exp_rd;
    bit          exp_err;
    int          n, exp_pops, cnt, waited;
    exp_rd = '0; exp_pops = 0; exp_err = 0;
    if (win != 1 && win != 2) exp_err = 1;
    else if (wr) begin
      if (win != 1) exp_err = 1;
      else begin
        cnt = txcnt[ch];
        for (int k = 0; k < 4; k++) if (be[k]) begin
          if (cnt >= TXCAP) break;
          exp_tx.push_back({4'(ch), wd[k*8 +: 8]});
          cnt++;
        end
      end
    end else begin
      if (sz == 3 || (win == 2 && sz == 0)) exp_err = 1;
      else begin
        n = (win == 1) ? ((sz == 0) ? 1 : (sz == 1) ? 2 : 4) : ((sz == 1) ? 1 : 2);
        for (int k = 0; k < n && k < rxq[ch].size(); k++) begin
          if (win == 1) exp_rd[k*8 +: 8] = rxq[ch][k][7:0];
          else          exp_rd[k*16 +: 16] = {rxq[ch][k][7:0], rxq[ch][k][15:8]};
          exp_pops++;
        end
      end
    end
    @(negedge clk);
    exp_ch = ch; pops_seen = 0;
    check("R10", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_page = {2'(ch), 2'(win)};
    req_size = 2'(sz); req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!rsp_valid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    check(rq, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check(rq, "rsp_err", {31'd0, rsp_err}, {31'd0, exp_err});
    check(rq, "rsp_rdata", rsp_rdata, exp_rd);
    check(rq, "pop count", pops_seen, exp_pops);
    @(negedge clk);
    check("R10", "single response pulse", {31'd0, rsp_valid}, 32'd0);
    check("R7", "pending pushes", exp_tx.size(), 0);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) txcnt[c] = 0;
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 20000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10", "reset ready", {31'd0, req_ready}, 32'd1);
    check("R10", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R10", "reset ovf", {28'd0, tx_ovf}, 32'd0);
    check("R10", "reset strobes", {24'd0, rx_pop, tx_push}, 32'd0);

    // R2 / R9 / R6: plain reads on channel 1
    for (int i = 0; i < 6; i++) load(1, 8'h10 + 8'(i), 8'hA0 + 8'(i));
    access("R2", 0, 1, 1, 2, 4'h0, 0);
    access("R9_R6", 0, 1, 1, 2, 4'h0, 0);
    access("R6", 0, 1, 1, 2, 4'h0, 0);
    // R2: byte and half-word reads on channel 0
    for (int i = 0; i < 3; i++) load(0, 8'h30 + 8'(i), 8'h00);
    access("R2", 0, 0, 1, 0, 4'h0, 0);
    access("R2", 0, 0, 1, 1, 4'h0, 0);
    access("R2", 0, 0, 1, 3, 4'h0, 0);

    // R3 / R4 / R5: paired window on channel 2
    for (int i = 0; i < 5; i++) load(2, 8'h50 + 8'(i), 8'h61 + 8'(i));
    access("R3", 0, 2, 2, 2, 4'h0, 0);
    access("R4", 0, 2, 2, 1, 4'h0, 0);
    access("R5", 0, 2, 2, 0, 4'h0, 0);
    access("R9_R3", 0, 2, 2, 2, 4'h0, 0);

    // R1: unused window codes
    access("R1", 0, 1, 0, 2, 4'h0, 0);
    access("R1", 1, 3, 3, 2, 4'hF, 32'h1234_5678);

    // R7: writes on channel 3
    access("R7", 1, 3, 1, 2, 4'hF, 32'h4433_2211);
    access("R7", 1, 3, 1, 2, 4'b0101, 32'hDDCC_BBAA);
    access("R7", 1, 3, 2, 2, 4'hF, 32'h9999_9999);
    access("R7", 1, 3, 1, 2, 4'h0, 32'h7777_7777);
    @(negedge clk);
    check("R8", "full but not overflowed", {28'd0, tx_ovf}, 32'd0);

    // R8: overflow on channel 0
    access("R8", 1, 0, 1, 2, 4'hF, 32'h0403_0201);
    access("R8", 1, 0, 1, 2, 4'hF, 32'h0807_0605);
    check("R8", "ovf set", {28'd0, tx_ovf}, 32'd1);
    drain(0);
    access("R8", 1, 0, 1, 2, 4'b0011, 32'h0000_0B0A);
    check("R8", "ovf sticky", {28'd0, tx_ovf}, 32'd1);
    drain(3);
    access("R11", 1, 3, 1, 2, 4'b1000, 32'hEE00_0000);
    check("R11", "other ovf untouched", {28'd0, tx_ovf}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule